// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block is the power-mode state machine of a small microcontroller. It tracks whether the chip is active, in sleep, in deep-sleep or in deep power-down. When the processor issues a sleep request, a control register picks the mode it enters. Flags record which kind of low-power mode was entered. Software reads them after wake-up and clears them by writing ones. Five general-purpose retention words keep their contents through deep power-down. Only a full power-on reset clears them.

Wake events are qualified per source. An external reset event and the real-time timer always wake the chip. The wake-up pin and the RF-field detector wake it only when their enable bits are set. A pending interrupt wakes the chip from sleep and deep-sleep, but not from deep power-down. Leaving deep power-down, or leaving power-on reset, runs a fixed power-up order. The order is: always-on oscillator, digital/flash regulator, analog regulator, always-on reset release, system oscillator. After a timed 64 µs settling wait, the system reset is released.

States:
- Power-up steps, in order: `S_PU_AOSC`, `S_PU_DLDO`, `S_PU_ALDO`, `S_PU_APOR`, and `S_PU_SOSC` (the timed wait).
- Run and sleep states: `S_ACTIVE`, `S_SLEEP`, `S_DSLEEP`, `S_DS_WAKE` (the oscillator re-settle after deep-sleep) and `S_DPD`.

Transitions:
- Each power-up step advances after one cycle. `S_PU_SOSC` goes to `S_ACTIVE` when the wait ends.
- `S_ACTIVE` goes to `S_SLEEP`, `S_DSLEEP` or `S_DPD` on a sleep request.
- `S_SLEEP` goes to `S_ACTIVE` on a wake.
- `S_DSLEEP` goes to `S_DS_WAKE` on a wake, then to `S_ACTIVE` when the wait ends.
- `S_DPD` goes to `S_PU_AOSC` on a qualified wake.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While `rst_n` is low, `aon_osc_en` is 1 and every other enable, `sys_rst_n` and `cpu_clk_en` are 0. Every register offset reads 0.
- R2: A power-up raises `dig_ldo_en`, `ana_ldo_en`, `aon_por_rel` and `sys_osc_en` in that order, one clock apart, with `aon_osc_en` already high.
- R3: `sys_rst_n` and `cpu_clk_en` rise exactly STABLE_CYC = CLK_KHZ*64/1000 cycles after `sys_osc_en` rises during power-up.
- R4: A one-cycle `cpu_sleep_req` in the active state selects the mode. It enters deep power-down if CTRL (offset 0) bit 0 is 1. Otherwise it enters deep-sleep if `cpu_deep` is 1, else sleep.
- R5: The outputs in each mode are:
  - Sleep: everything on except `cpu_clk_en`.
  - Deep-sleep: like sleep, and `sys_osc_en` is also 0.
  - Deep power-down: all enables and `sys_rst_n` are 0.
- R6: CTRL bit 8 is set on entry to sleep or deep-sleep, and CTRL bit 9 on entry to deep power-down. Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R7: In deep power-down, the wake sources are:
  - `wk_ext_rst` and `wk_timer` always wake.
  - `wk_pin` wakes only when CTRL bit 1 is set.
  - `wk_rf` wakes only when CTRL bit 2 is set.
  - `irq_pend` never wakes.

  A wake starts the R2 sequence.
- R8: From sleep, a qualified wake source or `irq_pend` returns to active on the next clock. From deep-sleep, `sys_osc_en` rises on the next clock. `cpu_clk_en` then follows after STABLE_CYC cycles, and `sys_rst_n` stays high throughout.
- R9: Retention words at offsets 2..6 are read/write. They keep their contents across deep power-down and wake, and are cleared only by `rst_n`. Leaving deep power-down clears CTRL bits 3:0 and PDCFG.
- R10: A wake event during a running power-up is ignored; the sequence is not restarted.
- R11: PDCFG (offset 1) bits NUM_PERIPH-1:0 drive `periph_pwr_en` directly.
- R12: `bod_irq` equals `bod_cmp` when CTRL bit 3 is set, and is 0 otherwise.
- R13: Unmapped offsets (7..15) and unused CTRL/PDCFG bits read 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| cpu_sleep_req | input | 1 | Processor sleep request pulse |
| cpu_deep | input | 1 | Processor asks for deep-sleep rather than sleep |
| irq_pend | input | 1 | Pending interrupt |
| wk_ext_rst | input | 1 | External reset wake event |
| wk_timer | input | 1 | Real-time timer reached its preset |
| wk_pin | input | 1 | Wake-up pin event |
| wk_rf | input | 1 | RF field detected |
| bod_cmp | input | 1 | Brown-out comparator output |
| bod_irq | output | 1 | Masked brown-out interrupt |
| aon_osc_en | output | 1 | Always-on oscillator enable |
| dig_ldo_en | output | 1 | Digital/flash regulator enable |
| ana_ldo_en | output | 1 | Analog regulator enable |
| aon_por_rel | output | 1 | Always-on domain reset release |
| sys_osc_en | output | 1 | System oscillator enable |
| sys_rst_n | output | 1 | System reset, active low |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_pwr_en | output | NUM_PERIPH | Analog peripheral power enables |

## Verification
The bench aims at the following cases:
- The exact settling count after the oscillator starts. An off-by-one counter would release the system reset a cycle early or late.
- A timer event held high through the whole power-up. A design that restarts on it would drop a regulator enable midway.
- Disabled pin and RF sources, and an interrupt, presented in deep power-down. A design with wrong gating would wake.
- Retention words read after deep power-down. A design that clears them on wake would return zeros.
- Flag writes with zero bits. A design that clears on any write would lose the flag.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [3:0] {
        S_PU_AOSC,
        S_PU_DLDO,
        S_PU_ALDO,
        S_PU_APOR,
        S_PU_SOSC,
        S_ACTIVE,
        S_SLEEP,
        S_DSLEEP,
        S_DS_WAKE,
        S_DPD
    } pmc_state_e;

    // configuration field of the control word, bit 0 upward: dpd_sel, pin_en, rf_en, bod_en
    typedef struct packed {
        logic bod_en;
        logic rf_en;
        logic pin_en;
        logic dpd_sel;
    } pmc_cfg_t;

    typedef struct packed {
        logic aon_osc;
        logic dig_ldo;
        logic ana_ldo;
        logic aon_por;
        logic sys_osc;
        logic sys_rst_n;
        logic cpu_clk;
    } pmc_pwr_t;

    localparam int CTRL_OFS  = 0;
    localparam int PDCFG_OFS = 1;
    localparam int GP_BASE   = 2;
    localparam int FB_SLP    = 8;
    localparam int FB_DPD    = 9;

endpackage

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual (
    input  logic ext_rst,
    input  logic timer,
    input  logic pin,
    input  logic rf,
    input  logic irq,
    input  logic pin_en,
    input  logic rf_en,
    output logic dpd_wake,
    output logic slp_wake
);
    // always-on domain sources; interrupt only counts while the core is powered
    assign dpd_wake = ext_rst | timer | (pin & pin_en) | (rf & rf_en);
    assign slp_wake = dpd_wake | irq;
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
    import pmc_pkg::*;
#(
    parameter int STABLE_CYC = 128
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sleep_req,
    input  logic     cpu_deep,
    input  logic     dpd_sel,
    input  logic     dpd_wake,
    input  logic     slp_wake,
    output pmc_pwr_t pwr,
    output logic     ent_slp,
    output logic     ent_dpd,
    output logic     dpd_exit
);
    localparam int CNT_W = $clog2(STABLE_CYC + 1);

    pmc_state_e state, nxt;
    logic [CNT_W-1:0] cnt;
    logic cnt_done;

    assign cnt_done = (cnt == CNT_W'(STABLE_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_PU_AOSC;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if ((state == S_PU_SOSC || state == S_DS_WAKE) && !cnt_done)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    always_comb begin
        nxt      = state;
        ent_slp  = 1'b0;
        ent_dpd  = 1'b0;
        dpd_exit = 1'b0;
        unique case (state)
            S_PU_AOSC: nxt = S_PU_DLDO;
            S_PU_DLDO: nxt = S_PU_ALDO;
            S_PU_ALDO: nxt = S_PU_APOR;
            S_PU_APOR: nxt = S_PU_SOSC;
            S_PU_SOSC: if (cnt_done) nxt = S_ACTIVE;
            S_ACTIVE: begin
                if (sleep_req) begin
                    if (dpd_sel) begin
                        nxt     = S_DPD;
                        ent_dpd = 1'b1;
                    end else begin
                        nxt     = cpu_deep ? S_DSLEEP : S_SLEEP;
                        ent_slp = 1'b1;
                    end
                end
            end
            S_SLEEP:   if (slp_wake) nxt = S_ACTIVE;
            S_DSLEEP:  if (slp_wake) nxt = S_DS_WAKE;
            S_DS_WAKE: if (cnt_done) nxt = S_ACTIVE;
            S_DPD: begin
                if (dpd_wake) begin
                    nxt      = S_PU_AOSC;
                    dpd_exit = 1'b1;
                end
            end
            default:   nxt = S_PU_AOSC;
        endcase
    end

    always_comb begin
        pwr = '0;
        unique case (state)
            S_PU_AOSC: pwr = 7'b1000000;
            S_PU_DLDO: pwr = 7'b1100000;
            S_PU_ALDO: pwr = 7'b1110000;
            S_PU_APOR: pwr = 7'b1111000;
            S_PU_SOSC: pwr = 7'b1111100;
            S_ACTIVE:  pwr = 7'b1111111;
            S_SLEEP:   pwr = 7'b1111110;
            S_DSLEEP:  pwr = 7'b1111010;
            S_DS_WAKE: pwr = 7'b1111110;
            S_DPD:     pwr = 7'b0000000;
            default:   pwr = '0;
        endcase
    end
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int NUM_GP     = 5,
    parameter int NUM_PERIPH = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic                  ent_slp,
    input  logic                  ent_dpd,
    input  logic                  dpd_exit,
    output pmc_cfg_t              cfg,
    output logic [NUM_PERIPH-1:0] pd_en
);
    localparam int CFG_W = $bits(pmc_cfg_t);

    logic sel_ctrl, sel_pd;
    logic slp_flag, dpd_flag;
    logic [NUM_GP-1:0][DATA_W-1:0] gp_q;

    assign sel_ctrl = we && (addr == ADDR_W'(CTRL_OFS));
    assign sel_pd   = we && (addr == ADDR_W'(PDCFG_OFS));

    // configuration lives in the switched domain: lost on leaving deep power-down
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg   <= '0;
            pd_en <= '0;
        end else if (dpd_exit) begin
            cfg   <= '0;
            pd_en <= '0;
        end else begin
            if (sel_ctrl) cfg   <= pmc_cfg_t'(wdata[CFG_W-1:0]);
            if (sel_pd)   pd_en <= wdata[NUM_PERIPH-1:0];
        end
    end

    // flags: set wins over a simultaneous write-one clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slp_flag <= 1'b0;
            dpd_flag <= 1'b0;
        end else begin
            slp_flag <= ent_slp | (slp_flag & ~(sel_ctrl & wdata[FB_SLP]));
            dpd_flag <= ent_dpd | (dpd_flag & ~(sel_ctrl & wdata[FB_DPD]));
        end
    end

    // retention words: only the power-on reset clears them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gp_q <= '0;
        end else begin
            for (int i = 0; i < NUM_GP; i++)
                if (we && addr == ADDR_W'(GP_BASE + i)) gp_q[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_OFS)) begin
            rdata[CFG_W-1:0] = cfg;
            rdata[FB_SLP]    = slp_flag;
            rdata[FB_DPD]    = dpd_flag;
        end else if (addr == ADDR_W'(PDCFG_OFS)) begin
            rdata[NUM_PERIPH-1:0] = pd_en;
        end
        for (int i = 0; i < NUM_GP; i++)
            if (addr == ADDR_W'(GP_BASE + i)) rdata = gp_q[i];
    end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
    import pmc_pkg::*;
#(
    parameter int CLK_KHZ    = 2000,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int NUM_GP     = 5,
    parameter int NUM_PERIPH = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  cpu_sleep_req,
    input  logic                  cpu_deep,
    input  logic                  irq_pend,
    input  logic                  wk_ext_rst,
    input  logic                  wk_timer,
    input  logic                  wk_pin,
    input  logic                  wk_rf,
    input  logic                  bod_cmp,
    output logic                  bod_irq,
    output logic                  aon_osc_en,
    output logic                  dig_ldo_en,
    output logic                  ana_ldo_en,
    output logic                  aon_por_rel,
    output logic                  sys_osc_en,
    output logic                  sys_rst_n,
    output logic                  cpu_clk_en,
    output logic [NUM_PERIPH-1:0] periph_pwr_en
);
    localparam int STABLE_CYC = CLK_KHZ * 64 / 1000;

    pmc_cfg_t cfg;
    pmc_pwr_t pwr;
    logic ent_slp, ent_dpd, dpd_exit;
    logic dpd_wake, slp_wake;

    pmc_wake_qual u_wake (
        .ext_rst  (wk_ext_rst),
        .timer    (wk_timer),
        .pin      (wk_pin),
        .rf       (wk_rf),
        .irq      (irq_pend),
        .pin_en   (cfg.pin_en),
        .rf_en    (cfg.rf_en),
        .dpd_wake (dpd_wake),
        .slp_wake (slp_wake)
    );

    pmc_seq #(.STABLE_CYC(STABLE_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (cpu_sleep_req),
        .cpu_deep  (cpu_deep),
        .dpd_sel   (cfg.dpd_sel),
        .dpd_wake  (dpd_wake),
        .slp_wake  (slp_wake),
        .pwr       (pwr),
        .ent_slp   (ent_slp),
        .ent_dpd   (ent_dpd),
        .dpd_exit  (dpd_exit)
    );

    pmc_regs #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .NUM_GP     (NUM_GP),
        .NUM_PERIPH (NUM_PERIPH)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .ent_slp  (ent_slp),
        .ent_dpd  (ent_dpd),
        .dpd_exit (dpd_exit),
        .cfg      (cfg),
        .pd_en    (periph_pwr_en)
    );

    assign bod_irq     = bod_cmp & cfg.bod_en;
    assign aon_osc_en  = pwr.aon_osc;
    assign dig_ldo_en  = pwr.dig_ldo;
    assign ana_ldo_en  = pwr.ana_ldo;
    assign aon_por_rel = pwr.aon_por;
    assign sys_osc_en  = pwr.sys_osc;
    assign sys_rst_n   = pwr.sys_rst_n;
    assign cpu_clk_en  = pwr.cpu_clk;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int STABLE_CYC = 128,
    parameter int NUM_PERIPH = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_we,
    input logic                  ent_dpd,
    input logic                  dpd_exit,
    input logic                  aon_osc_en,
    input logic                  dig_ldo_en,
    input logic                  ana_ldo_en,
    input logic                  aon_por_rel,
    input logic                  sys_osc_en,
    input logic                  sys_rst_n,
    input logic                  cpu_clk_en,
    input logic                  bod_cmp,
    input logic                  bod_irq,
    input logic [NUM_PERIPH-1:0] periph_pwr_en
);
    int unsigned osc_cnt;

    // cycles the system oscillator has run while the system is still in reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            osc_cnt <= 0;
        else if (sys_osc_en && !sys_rst_n) begin
            if (osc_cnt < STABLE_CYC + 2) osc_cnt <= osc_cnt + 1;
        end else
            osc_cnt <= 0;
    end

    p_pu_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dig_ldo_en || aon_osc_en) && (!ana_ldo_en || dig_ldo_en) &&
        (!aon_por_rel || ana_ldo_en) && (!sys_osc_en || aon_por_rel));

    p_osc_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> (osc_cnt == STABLE_CYC));

    p_dpd_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ent_dpd |=> (!sys_rst_n && !aon_osc_en && !cpu_clk_en));

    p_clk_needs_osc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (sys_rst_n && sys_osc_en));

    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_ldo_en && !sys_rst_n) |=> dig_ldo_en);

    p_pd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && !dpd_exit) |=> $stable(periph_pwr_en));

    p_bod_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bod_irq |-> bod_cmp);
endmodule

bind pwr_mode_ctl pmc_checker #(
    .STABLE_CYC (STABLE_CYC),
    .NUM_PERIPH (NUM_PERIPH)
) u_pmc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_we        (bus_we),
    .ent_dpd       (ent_dpd),
    .dpd_exit      (dpd_exit),
    .aon_osc_en    (aon_osc_en),
    .dig_ldo_en    (dig_ldo_en),
    .ana_ldo_en    (ana_ldo_en),
    .aon_por_rel   (aon_por_rel),
    .sys_osc_en    (sys_osc_en),
    .sys_rst_n     (sys_rst_n),
    .cpu_clk_en    (cpu_clk_en),
    .bod_cmp       (bod_cmp),
    .bod_irq       (bod_irq),
    .periph_pwr_en (periph_pwr_en)
);

// File: tb/test_pwr_mode_ctl.sv
module test_pwr_mode_ctl;
    localparam int CLK_KHZ = 2000;
    localparam int STABLE  = CLK_KHZ * 64 / 1000;
    localparam int NP      = 6;
    localparam int NG      = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_sleep_req = 1'b0, cpu_deep = 1'b0, irq_pend = 1'b0;
    logic        wk_ext_rst = 1'b0, wk_timer = 1'b0, wk_pin = 1'b0, wk_rf = 1'b0;
    logic        bod_cmp = 1'b0, bod_irq;
    logic        aon_osc_en, dig_ldo_en, ana_ldo_en, aon_por_rel;
    logic        sys_osc_en, sys_rst_n, cpu_clk_en;
    logic [NP-1:0] periph_pwr_en;

    int checks = 0;
    int fails  = 0;

    // bench model of the register state
    logic [3:0]    m_cfg = '0;
    logic          m_sf = 1'b0, m_df = 1'b0;
    logic [NP-1:0] m_pd = '0;
    logic [31:0]   m_gp [NG];

    pwr_mode_ctl #(.CLK_KHZ(CLK_KHZ), .NUM_PERIPH(NP), .NUM_GP(NG)) i_pwr_mode_ctl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_sleep_req(cpu_sleep_req),
        .cpu_deep(cpu_deep), .irq_pend(irq_pend), .wk_ext_rst(wk_ext_rst),
        .wk_timer(wk_timer), .wk_pin(wk_pin), .wk_rf(wk_rf), .bod_cmp(bod_cmp),
        .bod_irq(bod_irq), .aon_osc_en(aon_osc_en), .dig_ldo_en(dig_ldo_en),
        .ana_ldo_en(ana_ldo_en), .aon_por_rel(aon_por_rel), .sys_osc_en(sys_osc_en),
        .sys_rst_n(sys_rst_n), .cpu_clk_en(cpu_clk_en), .periph_pwr_en(periph_pwr_en)
    );

    always #4 clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic logic [6:0] pat();
        return {aon_osc_en, dig_ldo_en, ana_ldo_en, aon_por_rel, sys_osc_en, sys_rst_n, cpu_clk_en};
    endfunction

    // mode 0 sleep, 1 deep-sleep, 2 deep power-down, 3 active
    function automatic logic [6:0] mode_pat(int m);
        case (m)
            0: return 7'b1111110;
            1: return 7'b1111010;
            2: return 7'b0000000;
            default: return 7'b1111111;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        logic [31:0] d = '0;
        if (a == 0) begin d[3:0] = m_cfg; d[8] = m_sf; d[9] = m_df; end
        else if (a == 1) d[NP-1:0] = m_pd;
        else if (a >= 2 && a < 2 + NG) d = m_gp[a-2];
        return d;
    endfunction

    // src: 0 ext reset, 1 timer, 2 pin, 3 rf, 4 irq
    function automatic bit exp_wakes(int m, int src);
        case (src)
            0, 1: return 1'b1;
            2: return m_cfg[1];
            3: return m_cfg[2];
            default: return (m != 2);
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 4'(a);
        #1 d = bus_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a == 0) begin
            m_cfg = d[3:0];
            if (d[8]) m_sf = 1'b0;
            if (d[9]) m_df = 1'b0;
        end else if (a == 1) m_pd = d[NP-1:0];
        else if (a >= 2 && a < 2 + NG) m_gp[a-2] = d;
    endtask

    task automatic chk_regs(input string req);
        logic [31:0] d;
        for (int a = 0; a < 16; a++) begin
            rd(a, d);
            chk(req, d, exp_rd(a));
        end
    endtask

    task automatic set_src(input int src, input logic v);
        case (src)
            0: wk_ext_rst = v;
            1: wk_timer   = v;
            2: wk_pin     = v;
            3: wk_rf      = v;
            default: irq_pend = v;
        endcase
    endtask

    task automatic pulse_src(input int src);
        @(negedge clk);
        set_src(src, 1'b1);
        @(negedge clk);
        set_src(src, 1'b0);
    endtask

    // entered at a negedge where the first power-up step is showing
    task automatic pu_check(input bit noise);
        int n;
        chk("R2 step aosc", 32'(pat()), 32'(7'b1000000));
        @(negedge clk);
        if (noise) wk_timer = 1'b1;  // R10: event held during the sequence
        chk("R2 step dldo", 32'(pat()), 32'(7'b1100000));
        @(negedge clk);
        chk("R2 step aldo", 32'(pat()), 32'(7'b1110000));
        @(negedge clk);
        chk("R2 step apor", 32'(pat()), 32'(7'b1111000));
        @(negedge clk);
        chk("R2 step sosc", 32'(pat()), 32'(7'b1111100));
        n = 0;
        while (!sys_rst_n && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(noise ? "R10 wait not restarted" : "R3 settle cycles", n, STABLE);
        chk("R3 active after settle", 32'(pat()), 32'(7'b1111111));
        wk_timer = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NG; i++) m_gp[i] = '0;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", 32'(pat()), 32'(7'b1000000));
        chk_regs("R1 reset registers");
        rst_n = 1'b1;
        pu_check(1'b0);

        // R11 peripheral enables, R13 unmapped and unused bits
        wr(1, 32'hFFFF_FF2D);
        chk("R11 periph enables", 32'(periph_pwr_en), 32'(6'h2D));
        wr(0, 32'hFFFF_FCF0);
        for (int i = 0; i < NG; i++) wr(2 + i, $urandom());
        for (int a = 7; a < 16; a++) wr(a, 32'hFFFF_FFFF);
        chk_regs("R13 unmapped and unused bits");

        // R12 brown-out masking
        bod_cmp = 1'b1;
        #1 chk("R12 bod masked", 32'(bod_irq), 0);
        wr(0, 32'h8);
        #1 chk("R12 bod enabled", 32'(bod_irq), 1);
        bod_cmp = 1'b0;
        #1 chk("R12 bod follows cmp", 32'(bod_irq), 0);

        for (int it = 0; it < 40; it++) begin
            int m, src, n;
            bit found;
            logic [31:0] cw;
            m = $urandom_range(0, 2);
            if ($urandom_range(0, 1) == 1) wr(2 + $urandom_range(0, NG - 1), $urandom());
            if ($urandom_range(0, 2) == 0) wr(7 + $urandom_range(0, 8), $urandom());
            wr(1, $urandom());
            chk("R11 periph enables", 32'(periph_pwr_en), 32'(m_pd));
            cw = $urandom() & 32'h0000_030E;
            cw[0] = (m == 2);
            wr(0, cw);
            chk_regs("R6 flag write-one-clear");
            bod_cmp = $urandom_range(0, 1) == 1;
            #1 chk("R12 bod mask", 32'(bod_irq), 32'(bod_cmp & m_cfg[3]));
            bod_cmp = 1'b0;

            // enter the mode
            @(negedge clk);
            cpu_deep = (m == 1);
            cpu_sleep_req = 1'b1;
            @(negedge clk);
            cpu_sleep_req = 1'b0;
            if (m == 2) m_df = 1'b1; else m_sf = 1'b1;
            chk("R4 R5 mode outputs", 32'(pat()), 32'(mode_pat(m)));
            if (m != 2) chk_regs("R6 flags after entry");

            // unqualified sources are ignored
            found = 1'b0;
            src = 1;
            for (int t = 0; t < 6 && !found; t++) begin
                src = $urandom_range(0, 4);
                if (exp_wakes(m, src)) found = 1'b1;
                else begin
                    pulse_src(src);
                    chk(m == 2 ? "R7 gated source ignored" : "R8 gated source ignored",
                        32'(pat()), 32'(mode_pat(m)));
                end
            end
            if (!found) src = 1;

            pulse_src(src);
            if (m == 0) begin
                chk("R8 sleep wake", 32'(pat()), 32'(7'b1111111));
            end else if (m == 1) begin
                chk("R8 deep-sleep osc restart", 32'(pat()), 32'(7'b1111110));
                n = 0;
                while (!cpu_clk_en && n < 20000) begin
                    @(negedge clk);
                    n++;
                    if (!sys_rst_n) chk("R8 system reset held high", 0, 1);
                end
                chk("R8 deep-sleep settle", n, STABLE);
            end else begin
                pu_check($urandom_range(0, 1) == 1);
                m_cfg = '0;
                m_pd  = '0;
                chk("R9 periph cleared on wake", 32'(periph_pwr_en), 0);
                chk_regs("R9 retention after deep power-down");
                chk("R7 wake from deep power-down", 32'(m_df), 1);
            end
        end

        // R9 power-on reset clears retention words
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NG; i++) m_gp[i] = '0;
        m_cfg = '0; m_pd = '0; m_sf = 1'b0; m_df = 1'b0;
        chk_regs("R9 retention cleared by power-on reset");
        rst_n = 1'b1;
        pu_check(1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule